// File: doc/BRIEF.md
# Bus Cycle Ready Generator

This block produces the active-low ready indication that ends a processor bus cycle. Two ready sources can feed it. The synchronous source is a ready input with its own enable. The bench or the board must meet setup to the sampling edge for this source. The asynchronous source is a ready input with its own enable that may change at any time. It first passes through a flip-flop synchronizer, and only its resolved value is used. Both enables are active low, so an address decoder can pick the source for each access.

All logic runs on one edge of `clk`, called the sampling edge below. A design that samples on the falling edge of the system clock feeds an inverted system clock into `clk`. `phaseClk` is the half-rate processor phase. Ready sources are evaluated only when it is high. `statN` carries the two active-low bus status lines; the value all ones means no bus cycle is starting. The output is modelled as an open-drain pin. `rdyDriveLow` = 1 means the block pulls the ready line low, which is active. `rdyLevel` is the level seen on the line with only an external pull-up. It can be wired-AND with the levels of other ready drivers.

Top module: `rdygen_top`

## Requirements
- R1: When `phaseClk` = 1, `statN` = all ones and both `syncRdyN` and `syncEnN` are 0 at a sampling edge, `rdyDriveLow` is 1 after that edge.
- R2: The synchronous pair has no effect at an edge where `phaseClk` = 0, where any bit of `statN` is 0, or where either of the two inputs is 1.
- R3: The asynchronous pair passes through SYNC_STAGES (default 2) flip-flops before use. If both inputs go low just before edge k, `rdyDriveLow` can become 1 no earlier than after edge k+2, and only at an edge with `phaseClk` = 1. The synchronous inputs are not needed for this: while the resolved asynchronous pair is active, it alone asserts or keeps ready.
- R4: The resolved asynchronous pair counts as active only when the ready and enable values captured at the same edge are both 0.
- R5: Once `rdyDriveLow` rises, it stays 1 for at least MIN_HOLD (default 2) cycles, even if a bus cycle starts.
- R6: When the minimum hold has elapsed and any bit of `statN` is 0 at a sampling edge, `rdyDriveLow` is 0 after that edge.
- R7: When the minimum hold has elapsed, `phaseClk` = 1 and neither source is active at a sampling edge, `rdyDriveLow` is 0 after that edge.
- R8: At an edge with `phaseClk` = 0 and `statN` = all ones, `rdyDriveLow` keeps its value.
- R9: At every sampling edge with `rst` = 1, `rdyDriveLow` becomes 1. It then stays 1 after `rst` falls, until R6 or R7 releases it.
- R10: `rdyLevel` is always the complement of `rdyDriveLow`: 0 when the block pulls the line low, 1 when it floats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Active-high reset, forces ready active |
| phaseClk | input | 1 | Half-rate processor phase; ready sources are evaluated when high |
| statN | input | STAT_W | Active-low bus status; all ones = no cycle start |
| syncRdyN | input | 1 | Synchronous ready, active low |
| syncEnN | input | 1 | Enable for synchronous ready, active low |
| asyncRdyN | input | 1 | Asynchronous ready, active low |
| asyncEnN | input | 1 | Enable for asynchronous ready, active low |
| rdyDriveLow | output | 1 | 1 = open-drain driver pulls ready low |
| rdyLevel | output | 1 | Resolved ready level with a pull-up (0 = ready) |

## Verification
Two pairs of functions can land on the same edge. The minimum hold can collide with a bus-cycle start, and reset can collide with a bus-cycle start. The bench asserts ready from the synchronous pair and drives `statN` low on the very next edge. Ready must stay low for that edge and float only on the following one. It also holds `rst` high while `statN` is low and expects ready to stay active. The asynchronous path is judged by counting edges from input change to output rise. The first phase-high sample must miss, and the second must hit.

// File: rtl/rdygen_pkg.sv
package rdygen_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic setDrive;
    logic clrDrive;
    logic holdClr;
  } rdyStrobe_t;

  typedef enum logic [1:0] {
    ST_FLOAT = 2'd0,
    ST_HOLD  = 2'd1,
    ST_DRIVE = 2'd2
  } rdyState_t;

  typedef struct packed {
    logic rdyN;
    logic enN;
  } asyncPair_t;

  localparam asyncPair_t PAIR_IDLE = '{rdyN: 1'b1, enN: 1'b1};

endpackage

// File: rtl/rdygen_datapath.sv
module rdygen_datapath
  import rdygen_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HOLD    = 2,
  parameter int STAT_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phaseClk,
  input  logic [STAT_W-1:0] statN,
  input  logic              syncRdyN,
  input  logic              syncEnN,
  input  logic              asyncRdyN,
  input  logic              asyncEnN,
  input  rdyStrobe_t        strobe,
  output logic              syncHit,
  output logic              asyncHit,
  output logic              cycleStart,
  output logic              holdDone,
  output logic              driveLow
);

  localparam int HOLD_LIMIT = (MIN_HOLD > 1) ? MIN_HOLD - 1 : 0;
  localparam int CNT_W      = (HOLD_LIMIT > 1) ? $clog2(HOLD_LIMIT + 1) : 1;

  asyncPair_t [SYNC_STAGES-1:0] syncChain;
  asyncPair_t                   newPair;
  asyncPair_t                   resolved;
  logic                         busIdle;
  logic [CNT_W-1:0]             holdCnt;
  logic                         driveQ;

  assign newPair = '{rdyN: asyncRdyN, enN: asyncEnN};

  // synchronizer depth picked by parameter
  generate
    if (SYNC_STAGES == 1) begin : g_oneStage
      always_ff @(posedge clk) begin
        if (rst) syncChain <= PAIR_IDLE;
        else     syncChain <= newPair;
      end
    end else begin : g_multiStage
      always_ff @(posedge clk) begin
        if (rst) syncChain <= {SYNC_STAGES{PAIR_IDLE}};
        else     syncChain <= {syncChain[SYNC_STAGES-2:0], newPair};
      end
    end
  endgenerate

  assign resolved   = syncChain[SYNC_STAGES-1];
  assign busIdle    = (statN == {STAT_W{1'b1}});
  assign cycleStart = !busIdle;
  assign asyncHit   = phaseClk && !resolved.rdyN && !resolved.enN;
  assign syncHit    = phaseClk && busIdle && !syncRdyN && !syncEnN;

  // minimum hold counter
  assign holdDone = (holdCnt >= CNT_W'(HOLD_LIMIT));

  always_ff @(posedge clk) begin
    if (rst)                       holdCnt <= CNT_W'(HOLD_LIMIT);
    else if (strobe.holdClr)       holdCnt <= '0;
    else if (driveQ && !holdDone)  holdCnt <= holdCnt + CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst)                  driveQ <= 1'b1;
    else if (strobe.setDrive) driveQ <= 1'b1;
    else if (strobe.clrDrive) driveQ <= 1'b0;
  end

  assign driveLow = driveQ;

  // R5: minimum hold after assertion
  generate
    if (MIN_HOLD >= 2) begin : g_holdChk
      assert_min_hold_R5 : assert property (@(posedge clk) disable iff (rst)
        $rose(driveQ) |=> driveQ);
    end
  endgenerate

  // R3: assertion only happens at a phase-high edge
  assert_rise_phase_R3 : assert property (@(posedge clk) disable iff (rst)
    $rose(driveQ) |-> ($past(phaseClk) || $past(rst)));

  // R9: reset forces ready active
  assert_reset_drive_R9 : assert property (@(posedge clk)
    rst |=> driveQ);

endmodule

// File: rtl/rdygen_ctrl.sv
module rdygen_ctrl
  import rdygen_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       phaseClk,
  input  logic       syncHit,
  input  logic       asyncHit,
  input  logic       cycleStart,
  input  logic       holdDone,
  output rdyStrobe_t strobe
);

  rdyState_t state;
  rdyState_t nextState;
  logic      anyHit;
  logic      releaseNow;

  // asynchronous source wins; synchronous only matters without it
  assign anyHit     = asyncHit || syncHit;
  assign releaseNow = cycleStart || (phaseClk && !anyHit);

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      ST_FLOAT: begin
        if (!cycleStart && anyHit) begin
          strobe.setDrive = 1'b1;
          strobe.holdClr  = 1'b1;
          nextState       = ST_HOLD;
        end
      end
      ST_HOLD, ST_DRIVE: begin
        if (holdDone) begin
          if (releaseNow) begin
            strobe.clrDrive = 1'b1;
            nextState       = ST_FLOAT;
          end else begin
            nextState = ST_DRIVE;
          end
        end
      end
      default: nextState = ST_FLOAT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_DRIVE;
    else     state <= nextState;
  end

  // R5 / R7: never set and clear together
  always_comb begin
    assert_strobe_excl_R7 : assert (!(strobe.setDrive && strobe.clrDrive));
  end

  // R6: cycle start after hold floats the output
  assert_cycle_release_R6 : assert property (@(posedge clk) disable iff (rst)
    (cycleStart && holdDone && state != ST_FLOAT) |=> (state == ST_FLOAT));

endmodule

// File: rtl/rdygen_top.sv
module rdygen_top
  import rdygen_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_HOLD    = 2,
  parameter int STAT_W      = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              phaseClk,
  input  logic [STAT_W-1:0] statN,
  input  logic              syncRdyN,
  input  logic              syncEnN,
  input  logic              asyncRdyN,
  input  logic              asyncEnN,
  output logic              rdyDriveLow,
  output logic              rdyLevel
);

  rdyStrobe_t strobe;
  logic       syncHit;
  logic       asyncHit;
  logic       cycleStart;
  logic       holdDone;

  rdygen_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .phaseClk   (phaseClk),
    .syncHit    (syncHit),
    .asyncHit   (asyncHit),
    .cycleStart (cycleStart),
    .holdDone   (holdDone),
    .strobe     (strobe)
  );

  rdygen_datapath #(
    .SYNC_STAGES (SYNC_STAGES),
    .MIN_HOLD    (MIN_HOLD),
    .STAT_W      (STAT_W)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .phaseClk   (phaseClk),
    .statN      (statN),
    .syncRdyN   (syncRdyN),
    .syncEnN    (syncEnN),
    .asyncRdyN  (asyncRdyN),
    .asyncEnN   (asyncEnN),
    .strobe     (strobe),
    .syncHit    (syncHit),
    .asyncHit   (asyncHit),
    .cycleStart (cycleStart),
    .holdDone   (holdDone),
    .driveLow   (rdyDriveLow)
  );

  // open-drain with pull-up
  assign rdyLevel = ~rdyDriveLow;

  // R8: a floating output stays floating on phase-low idle edges
  assert_float_keep_R8 : assert property (@(posedge clk) disable iff (rst)
    (!$past(phaseClk) && $past(statN) == {STAT_W{1'b1}} && !$past(rdyDriveLow) && !$past(rst))
      |-> !rdyDriveLow);

endmodule

// File: tb/rdygen_top_bench.sv
module rdygen_top_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       phaseClk = 1'b0;
  logic [1:0] statN = 2'b11;
  logic       syncRdyN = 1'b1;
  logic       syncEnN = 1'b1;
  logic       asyncRdyN = 1'b1;
  logic       asyncEnN = 1'b1;
  logic       rdyDriveLow;
  logic       rdyLevel;
  logic       otherLevel = 1'b1;
  int         checks = 0;
  int         failures = 0;

  always #2 clk = ~clk;   // 250 MHz

  rdygen_top u_rdygen_top (
    .clk        (clk),
    .rst        (rst),
    .phaseClk   (phaseClk),
    .statN      (statN),
    .syncRdyN   (syncRdyN),
    .syncEnN    (syncEnN),
    .asyncRdyN  (asyncRdyN),
    .asyncEnN   (asyncEnN),
    .rdyDriveLow(rdyDriveLow),
    .rdyLevel   (rdyLevel)
  );

  // {rst, phase, statN[1:0], syncRdyN, syncEnN, asyncRdyN, asyncEnN, expDrive, req[3:0]}
  localparam int NVEC = 29;
  localparam logic [12:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 2'b11, 4'b1111, 1'b1, 4'd9},  // R9 reset
    {1'b1, 1'b1, 2'b11, 4'b1111, 1'b1, 4'd9},  // R9
    {1'b0, 1'b1, 2'b11, 4'b1111, 1'b0, 4'd7},  // R7 release, no source
    {1'b0, 1'b0, 2'b11, 4'b1111, 1'b0, 4'd8},  // R8
    {1'b0, 1'b1, 2'b11, 4'b0011, 1'b1, 4'd1},  // R1 sync assert
    {1'b0, 1'b0, 2'b00, 4'b1111, 1'b1, 4'd5},  // R5 hold beats cycle start
    {1'b0, 1'b1, 2'b00, 4'b1111, 1'b0, 4'd6},  // R6 cycle start floats
    {1'b0, 1'b0, 2'b11, 4'b1111, 1'b0, 4'd8},  // R8
    {1'b0, 1'b1, 2'b11, 4'b0111, 1'b0, 4'd2},  // R2 enable high
    {1'b0, 1'b0, 2'b11, 4'b0011, 1'b0, 4'd2},  // R2 phase low
    {1'b0, 1'b1, 2'b01, 4'b0011, 1'b0, 4'd2},  // R2 status not idle
    {1'b0, 1'b0, 2'b11, 4'b1100, 1'b0, 4'd3},  // R3 async enters sync
    {1'b0, 1'b1, 2'b11, 4'b1100, 1'b0, 4'd3},  // R3 first phase-high too early
    {1'b0, 1'b0, 2'b11, 4'b1100, 1'b0, 4'd3},  // R3
    {1'b0, 1'b1, 2'b11, 4'b1100, 1'b1, 4'd3},  // R3 second phase-high hits
    {1'b0, 1'b0, 2'b11, 4'b1100, 1'b1, 4'd5},  // R5
    {1'b0, 1'b1, 2'b11, 4'b1100, 1'b1, 4'd3},  // R3 async alone keeps ready
    {1'b0, 1'b0, 2'b11, 4'b1111, 1'b1, 4'd8},  // R8
    {1'b0, 1'b1, 2'b11, 4'b1111, 1'b1, 4'd3},  // R3 sync pipeline still active
    {1'b0, 1'b0, 2'b11, 4'b1111, 1'b1, 4'd8},  // R8
    {1'b0, 1'b1, 2'b11, 4'b1111, 1'b0, 4'd7},  // R7
    {1'b1, 1'b0, 2'b11, 4'b1111, 1'b1, 4'd9},  // R9 reset mid-run
    {1'b1, 1'b1, 2'b00, 4'b1111, 1'b1, 4'd9},  // R9 reset beats cycle start
    {1'b0, 1'b0, 2'b11, 4'b1111, 1'b1, 4'd9},  // R9 stays after reset
    {1'b0, 1'b1, 2'b11, 4'b1111, 1'b0, 4'd7},  // R7
    {1'b0, 1'b0, 2'b11, 4'b1101, 1'b0, 4'd4},  // R4 enable high
    {1'b0, 1'b1, 2'b11, 4'b1101, 1'b0, 4'd4},  // R4
    {1'b0, 1'b0, 2'b11, 4'b1111, 1'b0, 4'd4},  // R4
    {1'b0, 1'b1, 2'b11, 4'b1111, 1'b0, 4'd4}   // R4
  };

  task automatic checkBit(input string what, input int req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL R%0d %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic driveInputs(input logic r, input logic ph, input logic [1:0] st, input logic [3:0] rdy);
    @(negedge clk);
    rst = r; phaseClk = ph; statN = st;
    {syncRdyN, syncEnN, asyncRdyN, asyncEnN} = rdy;
    @(posedge clk);
    #1;
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failures++;
    $display("FAIL R7 watchdog actual=timeout expected=finished");
    finishRun();
  end

  initial begin
    for (int i = 0; i < NVEC; i++) begin
      logic [12:0] v;
      v = VEC[i];
      driveInputs(v[12], v[11], v[10:9], v[8:5]);
      checkBit($sformatf("row %0d drive", i), int'(v[3:0]), rdyDriveLow, v[4]);
      // R10: open-drain level and wired-AND with an idle neighbour
      checkBit($sformatf("row %0d level", i), 10, rdyLevel & otherLevel, ~v[4]);
    end

    // R4: ready and enable low in different cycles never meet in the synchronizer
    driveInputs(1'b0, 1'b0, 2'b11, 4'b1101);
    driveInputs(1'b0, 1'b1, 2'b11, 4'b1110);
    for (int k = 0; k < 6; k++) begin
      driveInputs(1'b0, k[0] ? 1'b0 : 1'b1, 2'b11, 4'b1111);
      checkBit("split async pair", 4, rdyDriveLow, 1'b0);
    end

    // R10: another driver pulling low dominates the wired line
    otherLevel = 1'b0;
    #1;
    checkBit("wired-AND neighbour low", 10, rdyLevel & otherLevel, 1'b0);
    otherLevel = 1'b1;

    // R1 + R5: sync assert, then cycle start and phase-high release
    driveInputs(1'b0, 1'b1, 2'b11, 4'b0011);
    checkBit("sync assert", 1, rdyDriveLow, 1'b1);
    driveInputs(1'b0, 1'b0, 2'b10, 4'b1111);
    checkBit("hold through cycle start", 5, rdyDriveLow, 1'b1);
    driveInputs(1'b0, 1'b1, 2'b10, 4'b1111);
    checkBit("cycle start after hold", 6, rdyDriveLow, 1'b0);

    finishRun();
  end

endmodule